// File: doc/BRIEF.md
# Row-Wear Tracking Byte Memory

This block is a synthesizable behavioural model of a byte-wide parallel memory with active-low chip, output and write enables, sampled on a system clock. Each bus cycle has two phases. The access phase opens when chip enable is first sampled low. The precharge phase opens when chip enable returns high. The array is split into blocks. Each block is a grid of rows by four columns. The low address bits pick the row, so any access wears the whole row it lands in.

Next to the data path, the model keeps a saturating wear counter for every (block, row) pair. A debug port reads any counter by block and row. Two sticky flags record timing faults. One is set when chip enable falls before the minimum precharge time has passed. The other is set when chip enable stays low longer than the allowed maximum. With `ROW_BITS = 8` the model is an 8K x 8 device. The default build uses `ROW_BITS = 6`, which keeps the array small when elaborated. The memory is a plain parallel bus with no stream payload, so every pin is a level-sampled control or data line and no valid/ready handshake applies.

Top module: `nvrow_mem`

## Requirements
- R1: Address decode. Bits `[ROW_BITS-1:0]` pick the row. Bits `[ROW_BITS+1:ROW_BITS]` pick the column. The top `BLK_BITS` bits pick the block. A row never spans two blocks.
- R2: The address is captured at the first clock edge that samples `ce_n` low after it was high. Address changes later in the same low period have no effect on that access.
- R3: A write stores `din` at the latched address on the first clock edge that samples `we_n` high after low, while `ce_n` is low in an open access. The written byte can be read in the very next access, with no busy period.
- R4: `dout_en` is 1 only when `ce_n` and `oe_n` are both low in an open access, starting one cycle after the falling sample. While `dout_en` is 1, `dout` carries the byte at the latched address. Otherwise `dout_en` is 0 and `dout` is 0.
- R5: Every access, read or write or neither, adds exactly one to the wear counter of its (block, row) pair, whatever its column.
- R6: Wear counters saturate at `2**CNT_W-1`.
- R7: If chip enable falls after fewer than `MIN_PRE` high samples, `pre_viol` is set one cycle later and stays set until reset.
- R8: If `ce_n` is sampled low on more than `MAX_LO` consecutive edges, `lo_viol` is set one cycle after the first excess sample and stays set until reset.
- R9: After reset, all counters read 0, both flags are 0, `dout_en` is 0, and the first access counts as properly precharged.
- R10: The same row index in different blocks has separate counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; write on its rise |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data, 0 when not driven |
| dout_en | output | 1 | High when the data bus would be driven |
| pre_viol | output | 1 | Sticky short-precharge flag |
| lo_viol | output | 1 | Sticky over-long chip-enable-low flag |
| dbg_block | input | BLK_BITS | Debug block select |
| dbg_row | input | ROW_BITS | Debug row select |
| dbg_count | output | CNT_W | Wear counter of the selected block and row |

## Verification
The bench touches all four columns of one row and expects that single row counter to rise by four. A design that decoded the row from the wrong bits would spread those hits across rows, and one that ignored the block bits would merge counters with matching rows in other blocks. Reads move the address right after the falling sample, so a design that reads the live address instead of the latched one returns the wrong byte. One row is hammered past 2**CNT_W-1 hits, which catches a counter that wraps to zero. The timing flags are driven exactly at their limits (precharge of exactly `MIN_PRE` samples, low of exactly `MAX_LO` samples) and then one step past them, so an off-by-one comparison raises a flag too early or never raises it.

// File: rtl/nvrow_pkg.sv
package nvrow_pkg;
  typedef enum logic {PH_ACCESS = 1'b0, PH_PRECHARGE = 1'b1} bus_phase_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/nvrow_cycle_timer.sv
module nvrow_cycle_timer
  import nvrow_pkg::*;
#(
  parameter int unsigned MIN_PRE = 3,
  parameter int unsigned MAX_LO  = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  output logic start,
  output logic open_acc,
  output logic pre_viol,
  output logic lo_viol
);
  localparam int unsigned HW = idx_bits(MIN_PRE);
  localparam int unsigned LW = idx_bits(MAX_LO);

  bus_phase_e      phase_q;
  logic [HW-1:0]   hi_run;
  logic [LW-1:0]   lo_run;

  assign start    = (phase_q == PH_PRECHARGE) && !ce_n;
  assign open_acc = (phase_q == PH_ACCESS) && !ce_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_PRECHARGE;
      hi_run   <= HW'(MIN_PRE);
      lo_run   <= '0;
      pre_viol <= 1'b0;
      lo_viol  <= 1'b0;
    end else begin
      phase_q <= ce_n ? PH_PRECHARGE : PH_ACCESS;
      if (ce_n) begin
        lo_run <= '0;
        if (hi_run < HW'(MIN_PRE)) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
        if (lo_run < LW'(MAX_LO)) lo_run <= lo_run + 1'b1;
        else                      lo_viol <= 1'b1;
      end
      if (start && (hi_run < HW'(MIN_PRE))) pre_viol <= 1'b1;
    end
  end
endmodule

// File: rtl/nvrow_wear.sv
module nvrow_wear #(
  parameter int unsigned IDX_W = 9,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  input  logic [IDX_W-1:0] bump_idx,
  input  logic [IDX_W-1:0] dbg_idx,
  output logic [CNT_W-1:0] dbg_count
);
  localparam int unsigned N = 1 << IDX_W;

  logic [CNT_W-1:0] wear [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) wear[i] <= '0;
    end else if (bump && (wear[bump_idx] != '1)) begin
      wear[bump_idx] <= wear[bump_idx] + 1'b1;
    end
  end

  assign dbg_count = wear[dbg_idx];
endmodule

// File: rtl/nvrow_array.sv
module nvrow_array #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];
endmodule

// File: rtl/nvrow_mem.sv
module nvrow_mem #(
  parameter int unsigned BLK_BITS = 3,
  parameter int unsigned ROW_BITS = 6,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned MIN_PRE  = 3,
  parameter int unsigned MAX_LO   = 40,
  localparam int unsigned COL_BITS = 2,
  localparam int unsigned ADDR_W   = BLK_BITS + COL_BITS + ROW_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce_n,
  input  logic                oe_n,
  input  logic                we_n,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   din,
  output logic [DATA_W-1:0]   dout,
  output logic                dout_en,
  output logic                pre_viol,
  output logic                lo_viol,
  input  logic [BLK_BITS-1:0] dbg_block,
  input  logic [ROW_BITS-1:0] dbg_row,
  output logic [CNT_W-1:0]    dbg_count
);
  localparam int unsigned IDX_W = BLK_BITS + ROW_BITS;

  logic              start, open_acc;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] rd_data;
  logic              wr_fire;
  logic [IDX_W-1:0]  hit_idx;

  nvrow_cycle_timer #(.MIN_PRE(MIN_PRE), .MAX_LO(MAX_LO)) u_timer (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n),
    .start(start), .open_acc(open_acc),
    .pre_viol(pre_viol), .lo_viol(lo_viol)
  );

  // R1: row from the low bits, block from the top bits; the column does not enter the index
  assign hit_idx = {addr[ADDR_W-1 -: BLK_BITS], addr[ROW_BITS-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      we_q   <= 1'b1;
    end else begin
      we_q <= we_n;
      if (start) addr_q <= addr;
    end
  end

  assign wr_fire = open_acc && we_n && !we_q;

  nvrow_wear #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_wear (
    .clk(clk), .rst_n(rst_n),
    .bump(start), .bump_idx(hit_idx),
    .dbg_idx({dbg_block, dbg_row}), .dbg_count(dbg_count)
  );

  nvrow_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk(clk), .wr_en(wr_fire), .wr_addr(addr_q), .wr_data(din),
    .rd_addr(addr_q), .rd_data(rd_data)
  );

  assign dout_en = open_acc && !oe_n;
  assign dout    = dout_en ? rd_data : '0;
endmodule

// File: rtl/nvrow_mem_chk.sv
module nvrow_mem_chk #(
  parameter int unsigned MIN_PRE = 3,
  parameter int unsigned MAX_LO  = 40
) (
  input logic clk,
  input logic rst_n,
  input logic ce_n,
  input logic oe_n,
  input logic dout_en,
  input logic pre_viol,
  input logic lo_viol
);
  int unsigned lows, highs;
  logic        ce_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lows    <= 0;
      highs   <= MIN_PRE;
      ce_seen <= 1'b1;
    end else begin
      ce_seen <= ce_n;
      lows    <= ce_n ? 0 : ((lows < MAX_LO + 1) ? lows + 1 : lows);
      highs   <= !ce_n ? 0 : ((highs < MIN_PRE) ? highs + 1 : highs);
    end
  end

  a_r4_drive_needs_enables: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> (!ce_n && !oe_n));
  a_r4_drive_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !ce_seen);
  a_r7_pre_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    pre_viol |=> pre_viol);
  a_r7_short_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && ce_seen && highs < MIN_PRE) |=> pre_viol);
  a_r8_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lo_viol |=> lo_viol);
  a_r8_long_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && lows >= MAX_LO) |=> lo_viol);
endmodule

bind nvrow_mem nvrow_mem_chk #(.MIN_PRE(MIN_PRE), .MAX_LO(MAX_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
  .dout_en(dout_en), .pre_viol(pre_viol), .lo_viol(lo_viol)
);

// File: tb/nvrow_mem_bench.sv
module nvrow_mem_bench;
  localparam int BLK_BITS = 3, ROW_BITS = 6, DATA_W = 8, CNT_W = 8;
  localparam int MIN_PRE = 3, MAX_LO = 40;
  localparam int ADDR_W = BLK_BITS + 2 + ROW_BITS;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NCNT = 1 << (BLK_BITS + ROW_BITS);
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] din = '0, dout;
  logic dout_en, pre_viol, lo_viol;
  logic [BLK_BITS-1:0] dbg_block = '0;
  logic [ROW_BITS-1:0] dbg_row = '0;
  logic [CNT_W-1:0] dbg_count;

  always #2 clk = ~clk;

  nvrow_mem u_nvrow_mem (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DATA_W-1:0] model [DEPTH];
  int exp_cnt [NCNT];
  int last_hi = MIN_PRE;
  bit exp_pre = 0, exp_lo = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int cidx(input int a);
    return ((a >> (ROW_BITS + 2)) << ROW_BITS) | (a & ((1 << ROW_BITS) - 1));
  endfunction

  task automatic access(input int a, input bit wr, input logic [DATA_W-1:0] d,
                        input int lo, input int hi, input bit chk);
    ce_n = 0; addr = ADDR_W'(a); oe_n = wr; we_n = 1;
    if (exp_cnt[cidx(a)] < CMAX) exp_cnt[cidx(a)]++;
    if (last_hi < MIN_PRE) exp_pre = 1;
    if (wr) begin
      @(negedge clk); we_n = 0; din = d;
      @(negedge clk); we_n = 1; model[a] = d;
      repeat (lo - 2) @(negedge clk);
    end else begin
      @(negedge clk);
      addr = ~ADDR_W'(a);
      if (chk) begin
        check(dout_en === 1'b1, "R4 read drive", int'(dout_en), 1);
        check(dout === model[a], "R2/R3 read data", int'(dout), int'(model[a]));
      end
      repeat (lo - 1) @(negedge clk);
    end
    if (lo > MAX_LO) exp_lo = 1;
    ce_n = 1; oe_n = 1; we_n = 1;
    repeat (hi) @(negedge clk);
    last_hi = hi;
  endtask

  task automatic peek(input int blk, input int row, input string req);
    dbg_block = BLK_BITS'(blk); dbg_row = ROW_BITS'(row);
    #1;
    check(int'(dbg_count) == exp_cnt[(blk << ROW_BITS) | row], req,
          int'(dbg_count), exp_cnt[(blk << ROW_BITS) | row]);
  endtask

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    int unused;
    unused = $urandom(32'h5EED);
    for (int i = 0; i < NCNT; i++) exp_cnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    check(pre_viol == 0 && lo_viol == 0, "R9 flags clear", int'({pre_viol, lo_viol}), 0);
    check(dout_en == 0 && dout == 0, "R9 bus idle", int'(dout_en), 0);
    peek(0, 0, "R9 counter zero");
    peek(7, 63, "R9 counter zero");

    // preload: every byte written, fresh precharge on the first one (R9)
    for (int a = 0; a < DEPTH; a++) access(a, 1, DATA_W'(a * 7 + 3), 3, MIN_PRE, 0);

    // R1/R5: four columns of one row -> that row +4, neighbours untouched
    for (int c = 0; c < 4; c++) access((2 << (ROW_BITS + 2)) | (c << ROW_BITS) | 5, 0, 0, 2, MIN_PRE, 1);
    peek(2, 5, "R1/R5 columns share row");
    peek(2, 6, "R1 neighbour row");
    // R10 same row in another block is separate
    access((3 << (ROW_BITS + 2)) | 9, 0, 0, 2, MIN_PRE, 1);
    peek(3, 9, "R10 block separate");
    peek(4, 9, "R10 block separate");

    // R3 back-to-back write then read
    access(100, 1, 8'hA5, 3, MIN_PRE, 0);
    access(100, 0, 0, 2, MIN_PRE, 1);

    // random mix, always within timing (R2/R3/R4/R5)
    for (int k = 0; k < 400; k++) begin
      int a, lo, hi; bit wr;
      a  = int'($urandom_range(DEPTH - 1));
      wr = 1'($urandom_range(1));
      lo = int'($urandom_range(MAX_LO, 3));
      hi = int'($urandom_range(MIN_PRE + 3, MIN_PRE));
      access(a, wr, DATA_W'($urandom), lo, hi, 1);
    end

    // R4: output enable without chip enable does not drive
    oe_n = 0;
    @(negedge clk);
    check(dout_en == 0 && dout == 0, "R4 no drive in precharge", int'(dout_en), 0);
    oe_n = 1;
    @(negedge clk);

    // R6 saturation on one row
    for (int k = 0; k < CMAX + 5; k++) access(17, 0, 0, 2, MIN_PRE, 0);
    peek(0, 17, "R6 saturate");

    // R7/R8 exact limits: no flags
    access(200, 0, 0, MAX_LO, MIN_PRE, 1);
    access(201, 0, 0, 2, MIN_PRE, 1);
    check(pre_viol == 0, "R7 exact precharge ok", int'(pre_viol), 0);
    check(lo_viol == 0, "R8 exact low ok", int'(lo_viol), 0);

    // R7 short precharge then next access
    access(202, 0, 0, 2, MIN_PRE - 1, 1);
    access(203, 0, 0, 2, MIN_PRE, 1);
    check(pre_viol == exp_pre, "R7 short precharge", int'(pre_viol), int'(exp_pre));
    check(lo_viol == 0, "R8 unaffected by R7", int'(lo_viol), 0);
    // R8 overlong low
    access(204, 0, 0, MAX_LO + 1, MIN_PRE, 1);
    check(lo_viol == exp_lo, "R8 long low", int'(lo_viol), int'(exp_lo));
    access(205, 0, 0, 2, MIN_PRE, 1);
    check(pre_viol == 1 && lo_viol == 1, "R7/R8 sticky", int'({pre_viol, lo_viol}), 3);

    // R5/R6/R10 full counter sweep
    for (int b = 0; b < (1 << BLK_BITS); b++)
      for (int r = 0; r < (1 << ROW_BITS); r++) peek(b, r, "R5 wear sweep");

    summary();
  end
endmodule